// File: doc/BRIEF.md
# Load-Use Stall Decision Unit

This block decides when an in-order five-stage integer pipeline with 32 architectural registers must hold back the instruction in decode for one cycle. It looks at the two source register numbers of the instruction in the decode latch. It also looks at the destination number, memory-read flag and register-write flag of the instruction one stage ahead, in the decode-to-execute latch. The only case it reacts to is a load followed at once by an instruction that reads the loaded register. In that case it freezes the program counter and the decode latch, and it sends zeroed controls into execute so that a bubble follows the load.

The stall decision is purely combinational from the latch contents. A thin clocked shell holds the program counter, the decode latch and the decode-to-execute latch, so the stall can be watched cycle by cycle at the ports. Fetched instruction fields are presented as plain inputs on every cycle, with no handshake. When the unit stalls, the fetch side sees the program counter frozen and must present the same instruction again, which it does naturally because the counter did not move. Forwarding, branches and the datapath are not part of this block.

Top module: `load_use_stall_unit`

## Requirements
- R1: The unit stalls, with `pc_we` low, exactly when the execute-latch instruction has memory-read set, a nonzero destination, and that destination equals the decode instruction's first or second source register.
- R2: During a stall, `dec_we` is low and `bubble_sel` is high. At the next clock the execute latch holds destination 0 with memory-read and register-write cleared.
- R3: An execute-latch destination of register 0 never causes a stall, even when both sources are 0.
- R4: When both sources match the load destination, the stall lasts exactly one cycle.
- R5: A producer with memory-read clear never causes a stall, whatever its destination matches.
- R6: When one unrelated instruction separates a load from its reader, no stall occurs.
- R7: A store that reads a register written by the ALU instruction just before it does not stall.
- R8: With no stall, `pc_we` and `dec_we` are high and `bubble_sel` is low. At the next clock the execute latch takes the decode instruction's destination and flags unchanged.
- R9: A stall never lasts two cycles in a row, because the same decode instruction is compared next against the bubble.
- R10: A synchronous active-high reset sets the program counter to 0 and clears both latches. After reset, the counter advances by `PC_STEP` on each clock where `pc_we` is high and holds when it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_rs | input | 5 | First source register of the fetched instruction |
| fetch_rt | input | 5 | Second source register of the fetched instruction |
| fetch_rd | input | 5 | Destination register of the fetched instruction |
| fetch_memrd | input | 1 | Fetched instruction reads memory (a load) |
| fetch_regwr | input | 1 | Fetched instruction writes a register |
| pc_q | output | PC_W | Current program counter |
| pc_we | output | 1 | Program counter write enable (low means stall) |
| dec_we | output | 1 | Decode latch write enable |
| bubble_sel | output | 1 | Selects zeroed controls into the execute latch |
| ex_rd | output | 5 | Destination held in the execute latch |
| ex_memrd | output | 1 | Memory-read flag held in the execute latch |
| ex_regwr | output | 1 | Register-write flag held in the execute latch |

## Verification
A wrong match or a missing zero guard shows in the same cycle, as a `pc_we` level that differs from the reference for the instruction sitting in decode. A stall that is dropped or doubled shows one clock later. The program counter then sits off by one step, and the execute latch holds a real load or a bubble where the other was due. A bubble that is not cleared also shows at that next clock, as nonzero fields in the execute latch. Any one of these faults leaves the counter shifted for every cycle after it.

// File: rtl/ldu_pkg.sv
package ldu_pkg;
  localparam int REG_AW  = 5;
  localparam int NUM_SRC = 2;

  typedef struct packed {
    logic [REG_AW-1:0] rs;
    logic [REG_AW-1:0] rt;
    logic [REG_AW-1:0] rd;
    logic              memrd;
    logic              regwr;
  } instr_f_t;

  localparam instr_f_t INSTR_NONE = '{rs: '0, rt: '0, rd: '0, memrd: 1'b0, regwr: 1'b0};
endpackage

// File: rtl/ldu_src_match.sv
module ldu_src_match #(
  parameter int NSRC = 2,
  parameter int AW   = 5
) (
  input  logic [NSRC-1:0][AW-1:0] src,
  input  logic [AW-1:0]           dst,
  output logic                    any_hit
);
  logic [NSRC-1:0] eq;

  generate
    for (genvar g = 0; g < NSRC; g++) begin : g_cmp
      assign eq[g] = (src[g] == dst);
    end
  endgenerate

  // A single OR: several matching sources still give one stall request.
  assign any_hit = |eq;
endmodule

// File: rtl/ldu_stall_ctrl.sv
module ldu_stall_ctrl #(
  parameter int AW = 5
) (
  input  logic          src_hit,
  input  logic          ex_load,
  input  logic [AW-1:0] ex_dst,
  output logic          pc_we,
  output logic          dec_we,
  output logic          bubble_sel
);
  logic dst_live;
  logic stall;

  assign dst_live   = |ex_dst;
  assign stall      = ex_load & dst_live & src_hit;
  assign pc_we      = ~stall;
  assign dec_we     = ~stall;
  assign bubble_sel = stall;
endmodule

// File: rtl/ldu_latches.sv
module ldu_latches
  import ldu_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int PC_STEP = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  instr_f_t        fetch_f,
  input  logic            pc_we,
  input  logic            dec_we,
  input  logic            bubble_sel,
  output logic [PC_W-1:0] pc,
  output instr_f_t        dec_f,
  output instr_f_t        ex_f
);
  localparam logic [PC_W-1:0] STEP = PC_W'(PC_STEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc    <= '0;
      dec_f <= INSTR_NONE;
      ex_f  <= INSTR_NONE;
    end else begin
      if (pc_we)  pc    <= pc + STEP;
      if (dec_we) dec_f <= fetch_f;
      ex_f <= bubble_sel ? INSTR_NONE : dec_f;
    end
  end

  p_pc_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !pc_we |=> pc == $past(pc));
  p_pc_step_r10: assert property (@(posedge clk) disable iff (rst)
    pc_we |=> pc == $past(pc) + STEP);
  p_bubble_r2: assert property (@(posedge clk) disable iff (rst)
    bubble_sel |=> (ex_f.rd == '0) && !ex_f.memrd && !ex_f.regwr);
  p_dec_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !dec_we |=> dec_f == $past(dec_f));
endmodule

// File: rtl/load_use_stall_unit.sv
module load_use_stall_unit
  import ldu_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int PC_STEP = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [4:0]        fetch_rs,
  input  logic [4:0]        fetch_rt,
  input  logic [4:0]        fetch_rd,
  input  logic              fetch_memrd,
  input  logic              fetch_regwr,
  output logic [PC_W-1:0]   pc_q,
  output logic              pc_we,
  output logic              dec_we,
  output logic              bubble_sel,
  output logic [4:0]        ex_rd,
  output logic              ex_memrd,
  output logic              ex_regwr
);
  instr_f_t fetch_f;
  instr_f_t dec_f;
  instr_f_t ex_f;
  logic [NUM_SRC-1:0][REG_AW-1:0] dec_srcs;
  logic src_hit;

  assign fetch_f = '{rs: fetch_rs, rt: fetch_rt, rd: fetch_rd,
                     memrd: fetch_memrd, regwr: fetch_regwr};
  assign dec_srcs = {dec_f.rt, dec_f.rs};

  ldu_src_match #(.NSRC(NUM_SRC), .AW(REG_AW)) u_match (
    .src     (dec_srcs),
    .dst     (ex_f.rd),
    .any_hit (src_hit)
  );

  ldu_stall_ctrl #(.AW(REG_AW)) u_ctrl (
    .src_hit    (src_hit),
    .ex_load    (ex_f.memrd),
    .ex_dst     (ex_f.rd),
    .pc_we      (pc_we),
    .dec_we     (dec_we),
    .bubble_sel (bubble_sel)
  );

  ldu_latches #(.PC_W(PC_W), .PC_STEP(PC_STEP)) u_lat (
    .clk        (clk),
    .rst        (rst),
    .fetch_f    (fetch_f),
    .pc_we      (pc_we),
    .dec_we     (dec_we),
    .bubble_sel (bubble_sel),
    .pc         (pc_q),
    .dec_f      (dec_f),
    .ex_f       (ex_f)
  );

  assign ex_rd    = ex_f.rd;
  assign ex_memrd = ex_f.memrd;
  assign ex_regwr = ex_f.regwr;

  p_zero_dst_r3: assert property (@(posedge clk) disable iff (rst)
    (ex_f.rd == '0) |-> pc_we);
  p_alu_no_stall_r5: assert property (@(posedge clk) disable iff (rst)
    !ex_f.memrd |-> pc_we);
  p_single_stall_r9: assert property (@(posedge clk) disable iff (rst)
    !pc_we |=> pc_we);
  p_stall_cause_r1: assert property (@(posedge clk) disable iff (rst)
    !pc_we |-> (ex_f.rd == dec_f.rs) || (ex_f.rd == dec_f.rt));
endmodule

// File: tb/load_use_stall_unit_tb_top.sv
module load_use_stall_unit_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [4:0] fetch_rs = '0, fetch_rt = '0, fetch_rd = '0;
  logic fetch_memrd = 1'b0, fetch_regwr = 1'b0;
  logic [31:0] pc_q;
  logic pc_we, dec_we, bubble_sel;
  logic [4:0] ex_rd;
  logic ex_memrd, ex_regwr;

  always #2 clk = ~clk;

  load_use_stall_unit dut_i (
    .clk(clk), .rst(rst), .fetch_rs(fetch_rs), .fetch_rt(fetch_rt),
    .fetch_rd(fetch_rd), .fetch_memrd(fetch_memrd), .fetch_regwr(fetch_regwr),
    .pc_q(pc_q), .pc_we(pc_we), .dec_we(dec_we), .bubble_sel(bubble_sel),
    .ex_rd(ex_rd), .ex_memrd(ex_memrd), .ex_regwr(ex_regwr)
  );

  localparam int NPROG = 18;
  int p_rs [NPROG], p_rt [NPROG], p_rd [NPROG], p_mr [NPROG], p_rw [NPROG];
  string p_tag [NPROG];

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic put(input int i, input int rs, input int rt, input int rd,
                     input int mr, input int rw, input string tag);
    p_rs[i] = rs; p_rt[i] = rt; p_rd[i] = rd; p_mr[i] = mr; p_rw[i] = rw; p_tag[i] = tag;
  endtask

  // Reference model state
  int k = 0;                 // index of next fetch; PC = 4*k
  int d_idx = -1;            // program index held in decode (-1 = empty)
  int e_rd = 0, e_mr = 0, e_rw = 0;

  function automatic int fld(input int idx, input int which);
    if (idx < 0 || idx >= NPROG) return 0;
    case (which)
      0: return p_rs[idx];
      1: return p_rt[idx];
      2: return p_rd[idx];
      3: return p_mr[idx];
      default: return p_rw[idx];
    endcase
  endfunction

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : main
    int stall_cycles = 0;
    int prev_stall = 0;
    for (int i = 0; i < NPROG; i++) put(i, 0, 0, 0, 0, 0, "R8");
    put(0, 1, 0, 2, 1, 1, "R8");   // load into r2
    put(1, 2, 3, 10, 0, 1, "R1");  // reads r2 right after: stall
    put(2, 1, 0, 0, 1, 1, "R8");   // load into r0
    put(3, 0, 0, 12, 0, 1, "R3");  // reads r0 twice: no stall
    put(4, 1, 0, 5, 1, 1, "R8");   // load into r5
    put(5, 5, 5, 13, 0, 1, "R4");  // both sources r5: one stall
    put(6, 1, 2, 6, 0, 1, "R8");   // ALU into r6
    put(7, 6, 6, 14, 0, 1, "R5");  // reads r6: no stall
    put(8, 1, 0, 7, 1, 1, "R8");   // load into r7
    put(9, 1, 2, 15, 0, 1, "R8");  // unrelated
    put(10, 7, 0, 16, 0, 1, "R6"); // reads r7 two later: no stall
    put(11, 1, 2, 4, 0, 1, "R8");  // ALU into r4
    put(12, 5, 4, 0, 0, 0, "R7");  // store reads r4: no stall
    put(13, 1, 0, 8, 1, 1, "R8");  // load into r8
    put(14, 9, 8, 11, 0, 1, "R1"); // second source matches: stall
    put(15, 8, 0, 17, 0, 1, "R6"); // r8 again after stall: no stall
    put(16, 1, 0, 31, 1, 1, "R8"); // load into r31
    put(17, 31, 0, 18, 0, 1, "R1");// stall

    fetch_rs = 5'(fld(0,0)); fetch_rt = 5'(fld(0,1)); fetch_rd = 5'(fld(0,2));
    fetch_memrd = fld(0,3)[0]; fetch_regwr = fld(0,4)[0];
    repeat (3) @(posedge clk);

    for (int cyc = 0; cyc < 40; cyc++) begin
      int exp_stall;
      string tag;
      @(negedge clk);
      if (cyc == 0) begin
        chk("R10", "reset pc", int'(pc_q), 0);
        chk("R10", "reset ex_rd", int'(ex_rd), 0);
        chk("R10", "reset ex_memrd", int'(ex_memrd), 0);
        rst = 1'b0;
      end
      exp_stall = (e_mr != 0 && e_rd != 0 &&
                   (e_rd == fld(d_idx,0) || e_rd == fld(d_idx,1))) ? 1 : 0;
      tag = (d_idx >= 0 && d_idx < NPROG) ? p_tag[d_idx] : "R8";
      if (exp_stall) tag = (tag == "R8") ? "R1" : tag;
      chk(tag, "pc_we", int'(pc_we), 1 - exp_stall);
      chk(exp_stall ? "R2" : "R8", "dec_we", int'(dec_we), 1 - exp_stall);
      chk(exp_stall ? "R2" : "R8", "bubble_sel", int'(bubble_sel), exp_stall);
      chk("R10", "pc", int'(pc_q), 4 * k);
      chk(prev_stall ? "R2" : "R8", "ex_rd", int'(ex_rd), e_rd);
      chk(prev_stall ? "R2" : "R8", "ex_memrd", int'(ex_memrd), e_mr);
      chk(prev_stall ? "R2" : "R8", "ex_regwr", int'(ex_regwr), e_rw);
      if (prev_stall && exp_stall) chk("R9", "back-to-back stall", 1, 0);
      if (!pc_we) stall_cycles++;
      // drive fetch for coming edge
      fetch_rs = 5'(fld(k,0)); fetch_rt = 5'(fld(k,1)); fetch_rd = 5'(fld(k,2));
      fetch_memrd = fld(k,3)[0]; fetch_regwr = fld(k,4)[0];
      // model next state
      if (exp_stall) begin
        e_rd = 0; e_mr = 0; e_rw = 0;
      end else begin
        e_rd = fld(d_idx,2); e_mr = fld(d_idx,3); e_rw = fld(d_idx,4);
        d_idx = k;
        k++;
      end
      prev_stall = exp_stall;
    end
    chk("R4", "total stall cycles", stall_cycles, 4);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule